// File: doc/BRIEF.md
# PHY Management Frame Register

This block gives a host one 32-bit word through which it talks to a modelled internal PHY. The host writes a frame word holding a start code, an opcode, a PHY address, a register address and 16 bits of data. On the next clock edge the block performs the requested read or write against a file of 32 sixteen-bit PHY registers. It stores the resulting word, with the completion flag in bit 16 set, so software can poll for the end of the transaction.

Writes to PHY register 0 are rewritten before they are stored. The reset request bit and the renegotiate request bit clear themselves. The renegotiate request also updates the status and partner ability registers. A link input keeps the link bits current and gives a one-cycle notice when the link changes. A separate configuration word holds two sense bits that software cannot write.

The host picks the target with `regSel`: 0 is the frame word and 1 is the configuration word.

Top module: `mgmt_frame_phy`

## Requirements
- R1: A write to the frame word is reflected on `frameWord` at the next clock edge with bit 16 set. Bits 31:17 keep the written value. Frame fields are: start 31:30, opcode 29:28, PHY address 27:23, register address 22:18, data 15:0.
- R2: If the start field is not 01, or the PHY address is not 1, no PHY register is read or written. The word is stored as written, with bit 16 set.
- R3: Opcode 01 stores data 15:0 in the addressed register. Opcode 10 returns the register contents in bits 15:0 of the stored word. Opcodes 00 and 11 access nothing.
- R4: A write to register 0 with bit 15 (reset request) set stores bit 15 cleared and bit 12 (negotiation enable) set.
- R5: A write to register 0 with bit 9 (renegotiate) set stores bit 9 cleared and sets status bit 5 (negotiation done) in register 1. When `linkUp` is high it also sets register 1 bit 2 (link) and register 5 bit 8 (partner 100 Mb/s full duplex).
- R6: Configuration word bits 9:8 ignore writes; bit 8 reads 1 and bit 9 reads 0. All other configuration bits take the written value. Reset value is 0x00000100.
- R7: After reset: `frameWord` is 0, register 4 is 0x0100, register 1 is 0x4028 with bit 2 set if `linkUp` is high during reset, and every other register is 0.
- R8: A change of `linkUp` sets register 1 bit 2 and register 5 bit 8 to the new link level at the next edge.
- R9: `linkIrq` is low after reset. It is high for the one cycle that follows each change of `linkUp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Host write strobe |
| regSel | input | 1 | Write target: 0 frame word, 1 configuration word |
| regWrData | input | 32 | Host write data |
| linkUp | input | 1 | Current link level |
| frameWord | output | 32 | Stored frame word |
| cfgWord | output | 32 | Configuration word |
| linkIrq | output | 1 | One-cycle pulse after a link change |

## Verification
The bench reads each register back through read frames after a write to it. This catches a design that stores register 0 untransformed, which would read back the reset or renegotiate bit. It sends frames with a wrong start code, a wrong PHY address and opcode 00, then re-reads a register it wrote earlier; a design that decoded loosely would corrupt that register. It runs the renegotiate sequence with the link up and with the link down, and a design that ignored the link level would raise link bits it should not. It also toggles the link and checks that the notice pulse lasts exactly one cycle. It writes all ones to the configuration word, so a design with writable sense bits would show bit 9 set or bit 8 cleared.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;

  // field positions inside the frame word
  localparam int START_HI = 31;
  localparam int OP_HI    = 29;
  localparam int PHY_HI   = 27;
  localparam int PHY_LO   = 23;
  localparam int REG_HI   = 22;
  localparam int REG_LO   = 18;
  localparam int DONE_BIT = 16;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;

  typedef struct packed {
    logic              frameLoad;
    logic              cfgLoad;
    logic              phyWr;
    logic              phyRd;
    logic [ADDR_W-1:0] regAddr;
    logic              linkEvt;
    logic              linkLevel;
  } strobe_t;
endpackage

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mgmt_frame_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [FRAME_W-1:0] regWrData,
  input  logic               linkUp,
  output strobe_t            cmd,
  output logic               linkIrq
);
  logic linkPrev;
  logic frameHit;
  logic accessOk;
  logic [1:0] opCode;

  always_comb begin
    frameHit = regWrEn && !regSel;
    opCode   = regWrData[OP_HI -: 2];
    accessOk = frameHit
            && (regWrData[START_HI -: 2] == START_CODE)
            && (regWrData[PHY_HI:PHY_LO] == PHY_ADDR[PHY_HI-PHY_LO:0]);
    cmd.frameLoad = frameHit;
    cmd.cfgLoad   = regWrEn && regSel;
    cmd.phyWr     = accessOk && (opCode == OP_WRITE);
    cmd.phyRd     = accessOk && (opCode == OP_READ);
    cmd.regAddr   = regWrData[REG_HI:REG_LO];
    cmd.linkEvt   = linkUp != linkPrev;
    cmd.linkLevel = linkUp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkPrev <= linkUp;
      linkIrq  <= 1'b0;
    end else begin
      linkPrev <= linkUp;
      linkIrq  <= cmd.linkEvt;
    end
  end

  // R2: a frame with a wrong start code or PHY address must not reach the file
  assert_bad_frame_no_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && (regWrData[START_HI -: 2] != START_CODE ||
     regWrData[PHY_HI:PHY_LO] != PHY_ADDR[PHY_HI-PHY_LO:0]))
    |-> !(cmd.phyWr || cmd.phyRd));

  // R9: a link change is followed by the notice pulse
  assert_irq_after_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp != $past(linkUp)) |=> linkIrq);
endmodule

// File: rtl/mgmt_frame_dp.sv
module mgmt_frame_dp
  import mgmt_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            cmd,
  input  logic [FRAME_W-1:0] regWrData,
  input  logic               linkUp,
  output logic [FRAME_W-1:0] frameWord,
  output logic [FRAME_W-1:0] cfgWord
);
  localparam int NUM_REGS = 2 ** ADDR_W;
  localparam int CTRL_IDX = 0;
  localparam int STAT_IDX = 1;
  localparam int ADV_IDX  = 4;
  localparam int LPA_IDX  = 5;
  localparam int RST_BIT  = 15;
  localparam int ANEN_BIT = 12;
  localparam int RENEG_BIT = 9;
  localparam int ANDONE_BIT = 5;
  localparam int LINK_BIT = 2;
  localparam int FD100_BIT = 8;
  localparam logic [DATA_W-1:0] ADV_RESET  = 16'h0100;
  localparam logic [DATA_W-1:0] STAT_RESET = 16'h4028;
  localparam logic [FRAME_W-1:0] CFG_RO_MASK = 32'h0000_0300;
  localparam logic [FRAME_W-1:0] CFG_RESET   = 32'h0000_0100;

  logic [DATA_W-1:0] phyRegs  [NUM_REGS];
  logic [DATA_W-1:0] nextRegs [NUM_REGS];
  logic [DATA_W-1:0] wrVal;
  logic [FRAME_W-1:0] frameNext;

  always_comb begin
    nextRegs = phyRegs;
    wrVal    = regWrData[DATA_W-1:0];
    if (cmd.phyWr) begin
      if (cmd.regAddr == ADDR_W'(CTRL_IDX)) begin
        if (wrVal[RST_BIT]) begin
          wrVal[RST_BIT]  = 1'b0;
          wrVal[ANEN_BIT] = 1'b1;
        end
        if (wrVal[RENEG_BIT]) begin
          wrVal[RENEG_BIT] = 1'b0;
          nextRegs[STAT_IDX][ANDONE_BIT] = 1'b1;
          if (linkUp) begin
            nextRegs[STAT_IDX][LINK_BIT] = 1'b1;
            nextRegs[LPA_IDX][FD100_BIT] = 1'b1;
          end
        end
      end
      nextRegs[cmd.regAddr] = wrVal;
    end
    if (cmd.linkEvt) begin
      nextRegs[STAT_IDX][LINK_BIT] = cmd.linkLevel;
      nextRegs[LPA_IDX][FD100_BIT] = cmd.linkLevel;
    end
    if (cmd.phyRd)
      frameNext = {regWrData[FRAME_W-1:DONE_BIT+1], 1'b1, phyRegs[cmd.regAddr]};
    else
      frameNext = regWrData | (FRAME_W'(1) << DONE_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) phyRegs[i] <= '0;
      phyRegs[ADV_IDX]  <= ADV_RESET;
      phyRegs[STAT_IDX] <= STAT_RESET | (DATA_W'(linkUp) << LINK_BIT);
      frameWord <= '0;
      cfgWord   <= CFG_RESET;
    end else begin
      phyRegs <= nextRegs;
      if (cmd.frameLoad) frameWord <= frameNext;
      if (cmd.cfgLoad)
        cfgWord <= (regWrData & ~CFG_RO_MASK) | (cfgWord & CFG_RO_MASK);
    end
  end

  // R1: every frame write leaves the completion flag set
  assert_done_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.frameLoad |=> frameWord[DONE_BIT]);

  // R4: request bits never stay stored in the control register
  assert_ctrl_selfclear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.phyWr && cmd.regAddr == ADDR_W'(CTRL_IDX))
    |=> (!phyRegs[CTRL_IDX][RST_BIT] && !phyRegs[CTRL_IDX][RENEG_BIT]));

  // R6: sense bits hold across configuration writes
  assert_sense_readonly_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cfgLoad |=> cfgWord[9:8] == $past(cfgWord[9:8]));

  // R8: link bits follow the new link level
  assert_link_tracks_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.linkEvt |=> (phyRegs[STAT_IDX][LINK_BIT] == $past(cmd.linkLevel) &&
                     phyRegs[LPA_IDX][FD100_BIT] == $past(cmd.linkLevel)));
endmodule

// File: rtl/mgmt_frame_phy.sv
module mgmt_frame_phy
  import mgmt_frame_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  input  logic        linkUp,
  output logic [31:0] frameWord,
  output logic [31:0] cfgWord,
  output logic        linkIrq
);
  strobe_t cmd;

  mgmt_frame_ctrl #(.PHY_ADDR(PHY_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .linkUp(linkUp), .cmd(cmd), .linkIrq(linkIrq)
  );

  mgmt_frame_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regWrData(regWrData),
    .linkUp(linkUp), .frameWord(frameWord), .cfgWord(cfgWord)
  );
endmodule

// File: tb/mgmt_frame_phy_bench.sv
`timescale 1ns/1ps
module mgmt_frame_phy_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic linkUp = 1'b1;
  logic [31:0] frameWord, cfgWord;
  logic linkIrq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mgmt_frame_phy u_mgmt_frame_phy (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .linkUp(linkUp), .frameWord(frameWord),
    .cfgWord(cfgWord), .linkIrq(linkIrq)
  );

  // {written word, expected frameWord, requirement number}
  localparam int NVEC = 19;
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h508CBEEF, 32'h508DBEEF, 8'd3},  // R3 write reg3
    {32'h608C0000, 32'h608DBEEF, 8'd3},  // R3 read reg3
    {32'h608E0000, 32'h608FBEEF, 8'd1},  // R1 bit17 kept
    {32'h60900000, 32'h60910100, 8'd7},  // R7 advertisement
    {32'h60840000, 32'h6085402C, 8'd7},  // R7 status, link up
    {32'h60880000, 32'h60890000, 8'd7},  // R7 other reg zero
    {32'h50808000, 32'h50818000, 8'd1},  // R1 raw word stored
    {32'h60800000, 32'h60811000, 8'd4},  // R4 reset bit cleared, enable set
    {32'h908C1234, 32'h908D1234, 8'd2},  // R2 bad start
    {32'h608C0000, 32'h608DBEEF, 8'd2},  // R2 reg3 untouched
    {32'h510C5555, 32'h510D5555, 8'd2},  // R2 wrong PHY address
    {32'h608C0000, 32'h608DBEEF, 8'd2},  // R2 reg3 untouched
    {32'h408C7777, 32'h408D7777, 8'd3},  // R3 opcode 00
    {32'h608C0000, 32'h608DBEEF, 8'd3},  // R3 reg3 untouched
    {32'h50840000, 32'h50850000, 8'd5},  // R5 clear status
    {32'h50800200, 32'h50810200, 8'd5},  // R5 renegotiate
    {32'h60840000, 32'h60850024, 8'd5},  // R5 done + link
    {32'h60940000, 32'h60950100, 8'd5},  // R5 partner 100FD
    {32'h60800000, 32'h60810000, 8'd5}   // R5 renegotiate bit cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic frameCheck(input string req, input logic [31:0] word, input logic [31:0] exp);
    hostWrite(1'b0, word);
    check(req, frameWord, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 frame reset", frameWord, 32'h0);
    check("R6 cfg reset", cfgWord, 32'h00000100);
    check("R9 irq reset", {31'b0, linkIrq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      hostWrite(1'b0, VEC[i][71:40]);
      checks++;
      if (frameWord !== VEC[i][39:8]) begin
        errors++;
        $display("FAIL R%0d vec %0d actual %08h expected %08h",
                 VEC[i][7:0], i, frameWord, VEC[i][39:8]);
      end
    end

    hostWrite(1'b1, 32'hFFFFFFFF);
    check("R6 cfg all ones", cfgWord, 32'hFFFFFDFF);
    hostWrite(1'b1, 32'h0);
    check("R6 cfg zero", cfgWord, 32'h00000100);

    @(negedge clk); linkUp = 1'b0;
    @(negedge clk);
    check("R9 irq after down", {31'b0, linkIrq}, 32'h1);
    @(negedge clk);
    check("R9 irq one cycle", {31'b0, linkIrq}, 32'h0);
    frameCheck("R8 status link down", 32'h60840000, 32'h60850020);
    frameCheck("R8 partner cleared", 32'h60940000, 32'h60950000);

    frameCheck("R5 clear status", 32'h50840000, 32'h50850000);
    frameCheck("R5 renegotiate down", 32'h50800200, 32'h50810200);
    frameCheck("R5 only done bit", 32'h60840000, 32'h60850020);
    frameCheck("R5 partner stays", 32'h60940000, 32'h60950000);

    @(negedge clk); linkUp = 1'b1;
    @(negedge clk);
    check("R9 irq after up", {31'b0, linkIrq}, 32'h1);
    @(negedge clk);
    check("R9 irq ends", {31'b0, linkIrq}, 32'h0);
    frameCheck("R8 status link up", 32'h60840000, 32'h60850024);
    frameCheck("R8 partner set", 32'h60940000, 32'h60950100);

    @(negedge clk); linkUp = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 no irq at reset", {31'b0, linkIrq}, 32'h0);
    frameCheck("R7 status link down reset", 32'h60840000, 32'h60854028);
    frameCheck("R7 control zero", 32'h60800000, 32'h60810000);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule